// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It takes the memory from power-on to an idle, fully programmed state. From reset it keeps the clock enable low for a parameterised settling interval, raises it with a no-operation on the command bus, and then issues the mandated command sequence:

- precharge of all banks;
- extended mode write that turns the DLL on;
- mode write that resets the DLL;
- a second precharge of all banks;
- two auto-refreshes;
- a final mode write with the DLL reset bit cleared.

Every gap between commands is counted in clock cycles from its own parameter. The ready flag is held back until the DLL lock interval, counted from the DLL-reset command, has also run out.

After a change of operating frequency the system raises the restart input while the block is ready. The block then repeats the tail of the sequence, from the DLL-reset mode write onward, including a fresh lock wait. Outside the ready state the block never drives anything but its own sequence. Once ready, it parks the bus in no-operation with the clock enable high.

Top module: `sdram_boot_seq`

## Requirements
- R1: A synchronous active-low reset, from any step, returns the block to the settling step. In the cycle after the reset edge, clock enable is low, the command is no-operation, bank and address are zero and the ready flag is low.
- R2: Clock enable stays low with no-operation for exactly T_STABLE cycles after reset. It is then high with no-operation for one cycle, and it never falls again without a reset.
- R3: Commands are encoded on (cs_n, ras_n, cas_n, we_n) as follows: no-operation 0111, precharge 0010 with address bit 10 high, auto-refresh 0001, and mode or extended-mode write 0000. No other code appears.
- R4: The commands come in this order: precharge, extended mode write, DLL-reset mode write, precharge, auto-refresh, auto-refresh, final mode write.
- R5: The extended mode write drives bank 01 and an all-zero address, so address bit 0 is low and the DLL is enabled.
- R6: Both mode writes drive bank 00. Their address carries the burst length code in bits 2..0 (2 gives 001, 4 gives 010, 8 gives 011), the interleave flag in bit 3, latency 3 (011) in bits 6..4, and bit 8 set only on the DLL-reset write. All other bits are zero.
- R7: Each command occupies one cycle and is followed by no-operation. The next command comes T_RP cycles after a precharge, T_MRD cycles after a mode write, and T_RFC cycles after an auto-refresh.
- R8: The ready flag rises at cycle max(c+T_LOCK, c+L+1). Here c is the cycle of the DLL-reset command and L = 2*T_MRD + T_RP + 2*T_RFC.
- R9: While ready, the block holds clock enable high and the bus in no-operation for as long as no restart arrives.
- R10: A restart sampled while ready clears the flag. The DLL-reset mode write appears in the next cycle, and the sequence from R4 onward runs again with the timing of R7 and R8.
- R11: A restart sampled while not ready has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Request to repeat the DLL-reset portion, honoured only when ready |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Address bus |
| done | output | 1 | Initialization complete |

## Verification
All outputs decode directly from registered state. A reset or restart sampled at a rising edge therefore shows on the pins in the cycle that edge begins. The ready flag follows the R8 formula exactly: at the DLL lock bound or one cycle after the final mode-write gap, whichever is later. The reference model in the bench lists the expected pin values for every cycle from the requirement timings. It rebuilds that list whenever reset was sampled and appends the repeated tail when restart is raised. The model is compared at every falling edge, so each result is checked in precisely the cycle it is due.

// File: rtl/boot_seq_pkg.sv
// Shared types and helpers for the SDRAM power-up sequencer.
// Assumes a single clock domain; all encodings are active-low bus codes.
package boot_seq_pkg;

    typedef enum logic [3:0] {
        ST_STABLE  = 4'd0,
        ST_CKE_ON  = 4'd1,
        ST_PRE_A   = 4'd2,
        ST_EMRS    = 4'd3,
        ST_MRS_DLL = 4'd4,
        ST_PRE_B   = 4'd5,
        ST_REF_A   = 4'd6,
        ST_REF_B   = 4'd7,
        ST_MRS_OP  = 4'd8,
        ST_LOCK    = 4'd9,
        ST_DONE    = 4'd10
    } step_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] BUS_NOP = 4'b0111;
    localparam logic [3:0] BUS_PRE = 4'b0010;
    localparam logic [3:0] BUS_REF = 4'b0001;
    localparam logic [3:0] BUS_MRW = 4'b0000;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Burst length to mode-word code.
    function automatic logic [2:0] bl_code(input int len);
        case (len)
            2:       return 3'b001;
            8:       return 3'b011;
            default: return 3'b010;
        endcase
    endfunction

    // Linear successor for the fixed-length steps.
    function automatic step_t step_after(input step_t s);
        case (s)
            ST_STABLE:  return ST_CKE_ON;
            ST_CKE_ON:  return ST_PRE_A;
            ST_PRE_A:   return ST_EMRS;
            ST_EMRS:    return ST_MRS_DLL;
            ST_MRS_DLL: return ST_PRE_B;
            ST_PRE_B:   return ST_REF_A;
            ST_REF_A:   return ST_REF_B;
            ST_REF_B:   return ST_MRS_OP;
            ST_MRS_OP:  return ST_LOCK;
            default:    return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/boot_step_timer.sv
// Cycle counter for the current step. Cleared on every step change and
// saturating at all ones. Assumes W is wide enough for the longest step.
module boot_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    // Count cycles spent in the present step.
    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (clear)           count <= '0;
        else if (count != {W{1'b1}}) count <= count + 1'b1;
    end
endmodule

// File: rtl/boot_lock_timer.sv
// Measures cycles since the DLL-reset command, saturating at T_LOCK.
// ready is high in any cycle where the next cycle is at least T_LOCK
// cycles after the command. Assumes T_LOCK >= 2.
module boot_lock_timer #(
    parameter int T_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int LW = $clog2(T_LOCK + 1);

    logic [LW-1:0] elapsed;

    // Restart at one on the command cycle, then count up to the bound.
    always_ff @(posedge clk) begin
        if (!rst_n)                        elapsed <= '0;
        else if (start)                    elapsed <= LW'(1);
        else if (elapsed != LW'(T_LOCK))   elapsed <= elapsed + 1'b1;
    end

    assign ready = (elapsed >= LW'(T_LOCK - 1));
endmodule

// File: rtl/boot_cmd_encode.sv
// Decodes the sequencer step and first-cycle flag into the memory pins.
// A command appears only in the first cycle of its step; all other cycles
// are no-operation. Assumes ADDR_W >= 11 and BA_W >= 1.
module boot_cmd_encode
    import boot_seq_pkg::*;
#(
    parameter int         ADDR_W     = 13,
    parameter int         BA_W       = 2,
    parameter logic [2:0] BL_CODE    = 3'b010,
    parameter bit         INTERLEAVE = 1'b0
) (
    input  step_t             step,
    input  logic              first,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [3:0]        bus;
    logic [ADDR_W-1:0] mode_w;

    // Operating mode word: burst length, burst type, latency three.
    always_comb begin
        mode_w      = '0;
        mode_w[2:0] = BL_CODE;
        mode_w[3]   = INTERLEAVE;
        mode_w[6:4] = 3'b011;
    end

    // Per-step pin values.
    always_comb begin
        cke  = (step != ST_STABLE);
        bus  = BUS_NOP;
        ba   = '0;
        addr = '0;
        if (first) begin
            case (step)
                ST_PRE_A, ST_PRE_B: begin
                    bus      = BUS_PRE;
                    addr[10] = 1'b1;
                end
                ST_EMRS: begin
                    bus   = BUS_MRW;
                    ba[0] = 1'b1;
                end
                ST_MRS_DLL: begin
                    bus     = BUS_MRW;
                    addr    = mode_w;
                    addr[8] = 1'b1;
                end
                ST_REF_A, ST_REF_B: bus = BUS_REF;
                ST_MRS_OP: begin
                    bus  = BUS_MRW;
                    addr = mode_w;
                end
                default: bus = BUS_NOP;
            endcase
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = bus;
endmodule

// File: rtl/sdram_boot_seq.sv
// SDRAM power-up initialization sequencer (top).
// Walks a fixed step list, each timed step lasting a parameter number of
// cycles, then waits for the DLL lock bound and reports done.
// Assumes every gap parameter is at least 2 and T_STABLE at least 1.
module sdram_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int T_STABLE   = 40000,
    parameter int T_RP       = 5,
    parameter int T_RFC      = 17,
    parameter int T_MRD      = 2,
    parameter int T_LOCK     = 200,
    parameter int BURST_LEN  = 4,
    parameter bit INTERLEAVE = 1'b0,
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int         MAX_LEN = imax(imax(T_STABLE, T_RP), imax(T_RFC, T_MRD));
    localparam int         CYC_W   = $clog2(MAX_LEN + 1);
    localparam logic [2:0] BL_CODE = bl_code(BURST_LEN);

    step_t            step_q, step_d;
    logic [CYC_W-1:0] cyc, step_len;
    logic             first, timed_end, lock_ok, dll_start;

    // Length in cycles of the present timed step.
    always_comb begin
        case (step_q)
            ST_STABLE:                step_len = CYC_W'(T_STABLE);
            ST_PRE_A, ST_PRE_B:       step_len = CYC_W'(T_RP);
            ST_EMRS, ST_MRS_DLL,
            ST_MRS_OP:                step_len = CYC_W'(T_MRD);
            ST_REF_A, ST_REF_B:       step_len = CYC_W'(T_RFC);
            default:                  step_len = CYC_W'(1);
        endcase
    end

    assign first     = (cyc == '0);
    assign timed_end = (cyc == step_len - 1'b1);

    // Choose the next step.
    always_comb begin
        step_d = step_q;
        case (step_q)
            ST_LOCK: if (lock_ok) step_d = ST_DONE;
            ST_DONE: if (restart) step_d = ST_MRS_DLL;
            default: if (timed_end) step_d = step_after(step_q);
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_STABLE;
        else        step_q <= step_d;
    end

    boot_step_timer #(.W(CYC_W)) u_step_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (step_d != step_q),
        .count (cyc)
    );

    assign dll_start = (step_q == ST_MRS_DLL) && first;

    boot_lock_timer #(.T_LOCK(T_LOCK)) u_lock_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dll_start),
        .ready (lock_ok)
    );

    boot_cmd_encode #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .BL_CODE    (BL_CODE),
        .INTERLEAVE (INTERLEAVE)
    ) u_enc (
        .step  (step_q),
        .first (first),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    assign done = (step_q == ST_DONE);
endmodule

// File: rtl/boot_seq_checker.sv
// Protocol checker for sdram_boot_seq, attached by bind. Watches only the
// pins; keeps its own count of cycles since the DLL-reset command.
module boot_seq_checker #(
    parameter int T_LOCK = 200,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    localparam int LW = $clog2(T_LOCK + 1);

    logic [3:0]    bus;
    logic          dll_cmd;
    logic [LW-1:0] since_dll;

    assign bus     = {cs_n, ras_n, cas_n, we_n};
    assign dll_cmd = (bus == 4'b0000) && (ba == '0) && addr[8];

    // Cycles since the last DLL-reset command seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_dll <= '0;
        else if (dll_cmd)                  since_dll <= LW'(1);
        else if (since_dll != LW'(T_LOCK)) since_dll <= since_dll + 1'b1;
    end

    a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);
    a_r2_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> bus == 4'b0111);
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0111) || (bus == 4'b0010) || (bus == 4'b0001) || (bus == 4'b0000));
    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0010) |-> addr[10]);
    a_r5_emrs_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0000 && ba == BA_W'(1)) |-> addr == '0);
    a_r7_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus != 4'b0111) |=> bus == 4'b0111);
    a_r8_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> since_dll == LW'(T_LOCK));
    a_r9_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cke && bus == 4'b0111));
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);
    a_r10_restart_reissues: assert property (@(posedge clk) disable iff (!rst_n)
        (done && restart) |=> (!done && bus == 4'b0000 && addr[8]));
endmodule

bind sdram_boot_seq boot_seq_checker #(
    .T_LOCK (T_LOCK),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .done    (done)
);

// File: tb/sim_sdram_boot_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural per-cycle reference list of expected pin values,
// compared at every falling edge.
module sim_sdram_boot_seq;
    localparam int T_STABLE = 100;
    localparam int T_RP     = 5;
    localparam int T_RFC    = 17;
    localparam int T_MRD    = 2;
    localparam int T_LOCK   = 200;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRW = 4'b0000;
    // R6: burst 8 -> 011, interleave bit 3, latency 011 in bits 6..4
    localparam logic [12:0] MODE = 13'(3 | (1 << 3) | (3 << 4));

    logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [12:0] addr;

    always #2.5 clk = ~clk;

    sdram_boot_seq #(
        .T_STABLE(T_STABLE), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .T_LOCK(T_LOCK), .BURST_LEN(8), .INTERLEAVE(1'b1),
        .ADDR_W(13), .BA_W(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done)
    );

    logic [19:0] eq[$];   // {cke, bus[3:0], ba[1:0], addr[12:0]} ; done separate
    bit          dq[$];
    string       tq[$];
    int checks = 0, errors = 0, cyc_no = 0;
    string override = "";

    task automatic push(input bit k, input logic [3:0] b, input logic [1:0] bk,
                        input logic [12:0] a, input bit d, input string t);
        eq.push_back({k, b, bk, a});
        dq.push_back(d);
        tq.push_back(t);
    endtask

    task automatic push_gap(input int n, input string t);
        for (int i = 0; i < n; i++) push(1, NOP, 0, 0, 0, t);
    endtask

    task automatic build_dll();
        int l;
        push(1, MRW, 0, MODE | 13'h100, 0, "R6");
        push_gap(T_MRD - 1, "R7");
        push(1, PRE, 0, 13'h400, 0, "R3");
        push_gap(T_RP - 1, "R7");
        push(1, REF, 0, 0, 0, "R4");
        push_gap(T_RFC - 1, "R7");
        push(1, REF, 0, 0, 0, "R4");
        push_gap(T_RFC - 1, "R7");
        push(1, MRW, 0, MODE, 0, "R6");
        push_gap(T_MRD - 1, "R7");
        l = 2 * T_MRD + T_RP + 2 * T_RFC;
        push_gap((T_LOCK - l > 1) ? T_LOCK - l : 1, "R8");
        push(1, NOP, 0, 0, 1, "R8");
    endtask

    task automatic build_full();
        eq.delete(); dq.delete(); tq.delete();
        for (int i = 0; i < T_STABLE; i++) push(0, NOP, 0, 0, 0, "R2");
        push(1, NOP, 0, 0, 0, "R2");
        push(1, PRE, 0, 13'h400, 0, "R4");
        push_gap(T_RP - 1, "R7");
        push(1, MRW, 2'b01, 0, 0, "R5");
        push_gap(T_MRD - 1, "R7");
        build_dll();
    endtask

    // One clock: note reset as sampled, compare at the falling edge.
    task automatic cycle();
        logic [19:0] e;
        bit ed;
        string t;
        bit rst_sampled = rst_n;
        @(negedge clk);
        cyc_no++;
        if (!rst_sampled) build_full();
        if (eq.size() > 0) begin
            e = eq.pop_front(); ed = dq.pop_front(); t = tq.pop_front();
        end else begin
            e = {1'b1, NOP, 2'b00, 13'h0}; ed = 1'b1; t = "R9";
        end
        if (!rst_sampled) t = "R1";
        if (override != "") t = override;
        checks++;
        if ({cke, cs_n, ras_n, cas_n, we_n, ba, addr} !== e || done !== ed) begin
            errors++;
            $display("FAIL %s cycle %0d: got cke=%b cmd=%b ba=%b addr=%h done=%b, exp cke=%b cmd=%b ba=%b addr=%h done=%b",
                     t, cyc_no, cke, {cs_n, ras_n, cas_n, we_n}, ba, addr, done,
                     e[19], e[18:15], e[14:13], e[12:0], ed);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic run_to_done();
        while (eq.size() > 0) cycle();
    endtask

    initial begin
        run(3);                       // R1: reset state
        rst_n = 1'b1;
        run(40);
        restart = 1'b1;               // R11: ignored during settling
        override = "R11";
        cycle();
        restart = 1'b0;
        run(3);
        override = "";
        run_to_done();                // R2..R8 full sequence
        run(8);                       // R9: parked
        restart = 1'b1;               // R10: repeat tail
        build_dll();
        override = "R10";
        cycle();
        override = "";
        restart = 1'b0;
        run_to_done();
        run(4);
        rst_n = 1'b0;                 // R1: reset from done
        run(2);
        rst_n = 1'b1;
        run(T_STABLE + 30);
        rst_n = 1'b0;                 // R1: reset mid-sequence
        cycle();
        rst_n = 1'b1;
        run_to_done();
        run(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got no end, exp end within 200000 cycles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule